// File: doc/BRIEF.md
# Programmable-Frame Serial Master with Word Queues

This block is a serial master for SPI-style links. Words queue up in a transmit buffer, and the engine sends each one out on the serial data output as a frame. At the same time it captures the same number of bits from the serial data input. Each captured word goes into a receive buffer. The host side reads the head word there and pops it with a strobe.

The frame shape is set on configuration inputs and must be held steady while a frame is in flight:

- word length from 1 to 32 bits;
- an 8-bit half-period divider, counted in ticks of a base clock-enable;
- which bit goes first;
- which clock edge samples the input;
- the level of the serial clock at rest;
- a send-only switch;
- the select line, with its own framing code and active level.

In the framing code, bit 0 asks for a pulse before the frame and bit 1 asks for a pulse after it. A code of zero keeps the select line asserted across the data bits instead.

Status outputs give the free space in the transmit buffer, the occupancy of the receive buffer, an idle indication and a sticky receive-overflow flag. Two strobes are provided. One aborts the engine and empties the transmit buffer. The other empties the receive buffer.

Top module: `spim_top`

## Requirements
- R1: After reset, `idle` is 1, `tx_free` equals TX_DEPTH, `rx_count` is 0, `rx_overflow` is 0, `sclk` sits at `cfg_clk_idle_hi` and `ssel` sits at its inactive level.
- R2: A frame carries `cfg_bits_m1`+1 bits, from 1 up to 32. The received word is right-aligned in `rx_data` and its unused upper bits read 0.
- R3: With `cfg_msb_first`=1, bit `cfg_bits_m1` is sent first and bit 0 last. With 0, bit 0 goes first. A received bit is stored at the position of the bit sent in the same slot.
- R4: Each bit spans two half-periods:
  - `sclk` rests at `cfg_clk_idle_hi`;
  - during the first half of a bit, `sclk` is `cfg_clk_idle_hi` XOR `cfg_sample_fall`, and during the second half it is the inverse;
  - `miso` is sampled at the transition in the middle of the bit;
  - `mosi` changes only at bit boundaries.
- R5: A half-period lasts `cfg_half_dly`+1 cycles in which `tick_en` is high. No serial activity advances while `tick_en` is low.
- R6: `cfg_sel_mode` bit 0 adds one select pulse, one half-period wide, before the data bits. Bit 1 adds one such pulse after them. With code 0, the select is active throughout the data bits. With any other code, the select is inactive during the data bits.
- R7: With `cfg_sel_act_low`=1, the active select level is 0 and the rest level is 1. With 0, the levels are the other way round.
- R8: At the end of each frame the received word is pushed into the receive buffer, unless `cfg_tx_only` is 1. `rx_data` shows the oldest word and `rx_pop` removes it.
- R9: A word that arrives while the receive buffer is full is dropped, and `rx_overflow` is set. The flag stays set until `rx_clear` or reset. `rx_clear` also empties the receive buffer.
- R10: `tx_load` while the transmit buffer is full is ignored, and `tx_free` reports TX_DEPTH minus the queued words.
- R11: `eng_reset` stops a frame mid-way: it returns `sclk` and `ssel` to rest, empties the transmit buffer and leaves the receive buffer untouched.
- R12: `idle` is 1 only when no frame is in flight and the transmit buffer is empty.
- R13: Queued words are sent back to back in load order, and their received words come out of the receive buffer in that same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base clock-enable that paces the serial timing |
| cfg_bits_m1 | input | 5 | Word length minus one |
| cfg_half_dly | input | 8 | Half-period length minus one, in ticks |
| cfg_msb_first | input | 1 | 1: highest bit first, 0: bit 0 first |
| cfg_sample_fall | input | 1 | Selects which clock edge samples the input |
| cfg_clk_idle_hi | input | 1 | Rest level of `sclk` |
| cfg_tx_only | input | 1 | 1: received words are discarded |
| cfg_sel_mode | input | 2 | Select framing code |
| cfg_sel_act_low | input | 1 | 1: select is active low |
| tx_data | input | 32 | Word to queue |
| tx_load | input | 1 | Queue `tx_data` |
| rx_data | output | 32 | Oldest received word |
| rx_pop | input | 1 | Remove the oldest received word |
| eng_reset | input | 1 | Abort the engine and empty the transmit buffer |
| rx_clear | input | 1 | Empty the receive buffer and clear the overflow flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | 1 | Slave select |
| tx_free | output | $clog2(TX_DEPTH+1) | Free transmit slots |
| rx_count | output | $clog2(RX_DEPTH+1) | Words held in the receive buffer |
| idle | output | 1 | No pending or active transfer |
| rx_overflow | output | 1 | Sticky receive-overflow flag |

## Verification
The hardest state to reach is a full transmit buffer. The engine takes a word the moment it is idle, so the buffer normally drains. The stimulus freezes the engine mid-frame by holding `tick_en` low, then loads more words than the buffer holds. The same frozen frame is then used to show that `eng_reset` aborts a transfer part-way through. Receive overflow is reached by sending more frames than the receive buffer holds, without popping any word, and then confirming that the oldest word survived.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } spim_state_e;

  // Position in the word of the bit carried in slot k of a frame.
  function automatic logic [4:0] slot_pos(input logic [4:0] k, input logic [4:0] last_idx,
                                          input logic msb_first);
    return msb_first ? (last_idx - k) : k;
  endfunction

  // Serial clock level for a given engine state and half of a bit.
  function automatic logic clk_level(input spim_state_e st, input logic second_half,
                                     input logic idle_hi, input logic sample_fall);
    if (st != ST_DATA) return idle_hi;
    return idle_hi ^ (second_half ? ~sample_fall : sample_fall);
  endfunction

  // Whether the select line is asserted in the given state.
  function automatic logic sel_asserted(input spim_state_e st, input logic [1:0] mode);
    if (mode == 2'd0) return st == ST_DATA;
    return (st == ST_PRE) || (st == ST_POST);
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10 / R9: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R10 / R9: a write into a full buffer leaves its occupancy unchanged
  a_r10_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/spim_timer.sv
module spim_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             hp_end
);

  logic [DLY_W-1:0] hcnt;

  assign hp_end = run && tick && (hcnt == dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hcnt <= '0;
    else if (!run)    hcnt <= '0;
    else if (hp_end)  hcnt <= '0;
    else if (tick)    hcnt <= hcnt + 1'b1;
  end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              tick,
  input  logic [4:0]        cfg_bits_m1,
  input  logic [DLY_W-1:0]  cfg_half_dly,
  input  logic              cfg_msb_first,
  input  logic              cfg_sample_fall,
  input  logic              cfg_clk_idle_hi,
  input  logic              cfg_tx_only,
  input  logic [1:0]        cfg_sel_mode,
  input  logic              cfg_sel_act_low,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ssel,
  output logic              busy
);

  spim_state_e       state;
  logic              half;
  logic [4:0]        k;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rx_sh;
  logic              hp_end;
  logic              run;
  logic              last_slot;
  logic [4:0]        pos;

  assign run       = (state != ST_IDLE) && !abort;
  assign last_slot = (k == cfg_bits_m1);
  assign pos       = slot_pos(k, cfg_bits_m1, cfg_msb_first);
  assign busy      = (state != ST_IDLE);
  assign tx_pop    = (state == ST_IDLE) && tx_valid && !abort;
  assign rx_push   = (state == ST_DATA) && hp_end && half && last_slot && !cfg_tx_only && !abort;
  assign rx_word   = rx_sh;

  assign sclk = clk_level(state, half, cfg_clk_idle_hi, cfg_sample_fall);
  assign mosi = (state == ST_DATA) ? word[pos] : 1'b0;
  assign ssel = sel_asserted(state, cfg_sel_mode) ^ cfg_sel_act_low;

  spim_timer #(.DLY_W(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tick),
    .dly    (cfg_half_dly),
    .hp_end (hp_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      half  <= 1'b0;
      k     <= '0;
      word  <= '0;
      rx_sh <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
      half  <= 1'b0;
      k     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (tx_valid) begin
          word  <= tx_word;
          rx_sh <= '0;
          k     <= '0;
          half  <= 1'b0;
          state <= cfg_sel_mode[0] ? ST_PRE : ST_DATA;
        end
        ST_PRE: if (hp_end) state <= ST_DATA;
        ST_DATA: if (hp_end) begin
          if (!half) begin
            rx_sh[pos] <= miso;
            half       <= 1'b1;
          end else begin
            half <= 1'b0;
            if (last_slot) state <= cfg_sel_mode[1] ? ST_POST : ST_IDLE;
            else           k <= k + 1'b1;
          end
        end
        ST_POST: if (hp_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: without a tick an active frame does not move the serial clock
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !abort) |=> $stable(sclk));

  // R11: an abort returns the engine to rest on the next cycle
  a_r11_abort_to_rest: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && (sclk == cfg_clk_idle_hi)));

  // R4: the data output only changes on the edge that ends a bit or a frame
  a_r4_mosi_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (state == ST_DATA) && half) |-> $stable(mosi));

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [4:0]        cfg_bits_m1,
  input  logic [7:0]        cfg_half_dly,
  input  logic              cfg_msb_first,
  input  logic              cfg_sample_fall,
  input  logic              cfg_clk_idle_hi,
  input  logic              cfg_tx_only,
  input  logic [1:0]        cfg_sel_mode,
  input  logic              cfg_sel_act_low,
  input  logic [31:0]       tx_data,
  input  logic              tx_load,
  output logic [31:0]       rx_data,
  input  logic              rx_pop,
  input  logic              eng_reset,
  input  logic              rx_clear,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssel,
  output logic [TCW-1:0]    tx_free,
  output logic [RCW-1:0]    rx_count,
  output logic              idle,
  output logic              rx_overflow
);

  localparam logic [TCW-1:0] TX_SLOTS = TCW'(TX_DEPTH);
  localparam logic [RCW-1:0] RX_SLOTS = RCW'(RX_DEPTH);

  logic [WORD_W-1:0] tx_head, rx_word;
  logic [TCW-1:0]    tx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_pop, rx_push, busy;

  spim_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (eng_reset),
    .push  (tx_load),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_head),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_clear),
    .push  (rx_push),
    .din   (rx_word),
    .pop   (rx_pop),
    .dout  (rx_data),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  spim_engine #(.DLY_W(8)) u_eng (
    .clk             (clk),
    .rst_n           (rst_n),
    .abort           (eng_reset),
    .tick            (tick_en),
    .cfg_bits_m1     (cfg_bits_m1),
    .cfg_half_dly    (cfg_half_dly),
    .cfg_msb_first   (cfg_msb_first),
    .cfg_sample_fall (cfg_sample_fall),
    .cfg_clk_idle_hi (cfg_clk_idle_hi),
    .cfg_tx_only     (cfg_tx_only),
    .cfg_sel_mode    (cfg_sel_mode),
    .cfg_sel_act_low (cfg_sel_act_low),
    .tx_valid        (!tx_empty),
    .tx_word         (tx_head),
    .tx_pop          (tx_pop),
    .rx_push         (rx_push),
    .rx_word         (rx_word),
    .miso            (miso),
    .sclk            (sclk),
    .mosi            (mosi),
    .ssel            (ssel),
    .busy            (busy)
  );

  assign tx_free = TX_SLOTS - tx_count;
  assign idle    = !busy && tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rx_overflow <= 1'b0;
    else if (rx_clear)           rx_overflow <= 1'b0;
    else if (rx_push && rx_full) rx_overflow <= 1'b1;
  end

  // R8: send-only operation never adds to the receive buffer
  a_r8_tx_only_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tx_only |=> (rx_count <= $past(rx_count)));

  // R9: the overflow flag holds until the clear strobe
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !rx_clear) |=> rx_overflow);

  // R9: the flag only rises when the receive buffer was full
  a_r9_overflow_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overflow) |-> ($past(rx_count) == RX_SLOTS));

  // R12: idle implies the transmit buffer is empty
  a_r12_idle_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (tx_free == TX_SLOTS));

endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;

  localparam int TXD = 4;
  localparam int RXD = 4;

  typedef struct packed {
    logic [4:0]  m1;
    logic        msb;
    logic        sf;
    logic        cpol;
    logic [1:0]  mode;
    logic        alow;
    logic [7:0]  dly;
    logic [31:0] txw;
    logic [31:0] rxw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5'd7,  1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'd0, 32'h0000_00A5, 32'h0000_003C},
    '{5'd7,  1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 8'd2, 32'h0000_0096, 32'h0000_005A},
    '{5'd31, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 8'd1, 32'hDEAD_BEEF, 32'h1234_5678},
    '{5'd0,  1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 8'd3, 32'h0000_0001, 32'h0000_0001},
    '{5'd12, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 8'd0, 32'h0000_1ABC, 32'h0000_0F0F},
    '{5'd4,  1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 8'd4, 32'h0000_0013, 32'h0000_000B}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic [4:0] c_m1 = 5'd7;
  logic [7:0] c_dly = 8'd0;
  logic c_msb = 1'b0, c_sf = 1'b0, c_cpol = 1'b0, c_txo = 1'b0, c_alow = 1'b1;
  logic [1:0] c_mode = 2'd0;
  logic [31:0] tx_data = '0;
  logic tx_load = 1'b0, rx_pop = 1'b0, eng_reset = 1'b0, rx_clear = 1'b0;
  logic miso_b;
  logic [31:0] rx_data;
  logic sclk, mosi, ssel, idle, rx_overflow;
  logic [2:0] tx_free, rx_count;

  always #5 clk = ~clk;

  spim_top #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cfg_bits_m1(c_m1), .cfg_half_dly(c_dly), .cfg_msb_first(c_msb),
    .cfg_sample_fall(c_sf), .cfg_clk_idle_hi(c_cpol), .cfg_tx_only(c_txo),
    .cfg_sel_mode(c_mode), .cfg_sel_act_low(c_alow),
    .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data), .rx_pop(rx_pop),
    .eng_reset(eng_reset), .rx_clear(rx_clear),
    .sclk(sclk), .mosi(mosi), .miso(miso_b), .ssel(ssel),
    .tx_free(tx_free), .rx_count(rx_count), .idle(idle), .rx_overflow(rx_overflow)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tick_mode = 0;
  bit wd_hit = 0;

  // slave-side model state
  bit mon_en = 0, loop = 0;
  logic [31:0] mon_rx = '0, mosi_cap = '0;
  int nsamp, ntr, t_first, hp_meas, pre_p, post_p, bad_sel;
  logic prev_sclk, prev_act;
  vec_t v;

  function automatic int bpos(input int k, input int len, input logic msb);
    return msb ? (len - 1 - k) : k;
  endfunction

  function automatic logic [31:0] lmask(input int len);
    logic [63:0] m;
    m = (64'd1 << len) - 64'd1;
    return m[31:0];
  endfunction

  wire act = ssel ^ c_alow;

  always_comb begin
    int kk;
    kk = (nsamp < int'(c_m1) + 1) ? nsamp : int'(c_m1);
    if (loop) miso_b = mosi;
    else      miso_b = mon_rx[bpos(kk, int'(c_m1) + 1, c_msb)];
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (tick_mode == 0) tick_en = 1'b1;
    else if (tick_mode == 1) tick_en = 1'b0;
    else tick_en = ~tick_en;
    if (!mon_en) begin
      nsamp = 0; ntr = 0; t_first = 0; hp_meas = 0; pre_p = 0; post_p = 0; bad_sel = 0;
      mosi_cap = '0; prev_sclk = sclk; prev_act = act;
    end else begin
      if (sclk != prev_sclk) begin
        ntr++;
        if (ntr == 1) t_first = cyc;
        if (ntr == 2) hp_meas = cyc - t_first;
        if (sclk == (c_cpol ^ ~c_sf)) begin
          if (nsamp < int'(c_m1) + 1) mosi_cap[bpos(nsamp, int'(c_m1) + 1, c_msb)] = mosi;
          if ((c_mode == 2'd0) ? !act : act) bad_sel++;
          nsamp++;
        end
      end
      if (act && !prev_act) begin
        if (nsamp == 0) pre_p++;
        else post_p++;
      end
      prev_sclk = sclk;
      prev_act = act;
    end
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic load(input logic [31:0] w);
    tx_data = w; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic pop1();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5000 && !idle; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(tx_free == 3'(TXD), "R1 tx_free", tx_free, TXD);
    chk(rx_count == 3'd0, "R1 rx_count", rx_count, 0);
    chk(rx_overflow == 1'b0, "R1 overflow", rx_overflow, 0);
    chk(sclk == 1'b0, "R1 sclk rest", sclk, 0);
    chk(ssel == 1'b1, "R1 ssel rest", ssel, 1);

    // table of frame shapes: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 6; i++) begin
      int len;
      v = VECS[i];
      len = int'(v.m1) + 1;
      c_m1 = v.m1; c_msb = v.msb; c_sf = v.sf; c_cpol = v.cpol;
      c_mode = v.mode; c_alow = v.alow; c_dly = v.dly; c_txo = 1'b0;
      loop = 0; mon_rx = v.rxw;
      repeat (3) @(negedge clk);
      mon_en = 1;
      load(v.txw);
      wait_idle();
      chk(nsamp == len, "R2 bit count", nsamp, len);
      chk(mosi_cap == (v.txw & lmask(len)), "R3 sent word", mosi_cap, v.txw & lmask(len));
      chk(rx_count == 3'd1, "R8 rx pushed", rx_count, 1);
      chk(rx_data == (v.rxw & lmask(len)), "R2 received word", rx_data, v.rxw & lmask(len));
      chk(hp_meas == int'(v.dly) + 1, "R5 half period", hp_meas, int'(v.dly) + 1);
      chk(pre_p == int'((v.mode == 2'd0) || v.mode[0]), "R6 pre pulse", pre_p,
          (v.mode == 2'd0) || v.mode[0]);
      chk(post_p == int'(v.mode[1]), "R6 post pulse", post_p, v.mode[1]);
      chk(bad_sel == 0, "R6 select during data", bad_sel, 0);
      chk(sclk == v.cpol, "R4 sclk rest level", sclk, v.cpol);
      chk(ssel == v.alow, "R7 ssel rest level", ssel, v.alow);
      mon_en = 0;
      pop1();
      chk(rx_count == 3'd0, "R8 pop", rx_count, 0);
    end

    // back to default shape
    c_m1 = 5'd7; c_msb = 1'b0; c_sf = 1'b0; c_cpol = 1'b0;
    c_mode = 2'd0; c_alow = 1'b1; c_dly = 8'd0;
    repeat (3) @(negedge clk);

    // R5: divided tick doubles the half period
    tick_mode = 2; c_dly = 8'd1; mon_rx = 32'h55;
    repeat (3) @(negedge clk);
    mon_en = 1;
    load(32'h3C);
    wait_idle();
    chk(hp_meas == 4, "R5 divided tick", hp_meas, 4);
    mon_en = 0;
    pop1();
    tick_mode = 0; c_dly = 8'd0;
    repeat (3) @(negedge clk);

    // R13 and R12: back to back in order via loopback
    loop = 1;
    load(32'h11);
    load(32'hE7);
    @(negedge clk);
    chk(idle == 1'b0, "R12 busy while pending", idle, 0);
    wait_idle();
    chk(idle == 1'b1, "R12 idle after drain", idle, 1);
    chk(rx_count == 3'd2, "R13 both received", rx_count, 2);
    chk(rx_data == 32'h11, "R13 first word", rx_data, 32'h11);
    pop1();
    chk(rx_data == 32'hE7, "R13 second word", rx_data, 32'hE7);

    // R10 and R11: freeze engine mid-frame, overfill, then abort
    tick_mode = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < TXD + 2; i++) load(32'h100 + 32'(i));
    @(negedge clk);
    chk(tx_free == 3'd0, "R10 full ignores load", tx_free, 0);
    chk(idle == 1'b0, "R12 not idle when stalled", idle, 0);
    eng_reset = 1'b1;
    @(negedge clk);
    eng_reset = 1'b0;
    chk(tx_free == 3'(TXD), "R11 tx emptied", tx_free, TXD);
    chk(idle == 1'b1, "R11 idle after abort", idle, 1);
    chk(sclk == 1'b0, "R11 sclk rest", sclk, 0);
    chk(ssel == 1'b1, "R11 ssel rest", ssel, 1);
    chk(rx_count == 3'd1, "R11 rx untouched", rx_count, 1);
    pop1();
    tick_mode = 0;
    repeat (2) @(negedge clk);

    // R8: send-only frames add nothing
    c_txo = 1'b1;
    load(32'h5A);
    wait_idle();
    chk(rx_count == 3'd0, "R8 send-only", rx_count, 0);
    c_txo = 1'b0;

    // R9: overflow
    for (int i = 0; i < RXD + 1; i++) begin
      load(32'h20 + 32'(i));
      wait_idle();
    end
    chk(rx_count == 3'(RXD), "R9 buffer full", rx_count, RXD);
    chk(rx_overflow == 1'b1, "R9 flag set", rx_overflow, 1);
    chk(rx_data == 32'h20, "R9 oldest kept", rx_data, 32'h20);
    repeat (5) @(negedge clk);
    chk(rx_overflow == 1'b1, "R9 flag sticky", rx_overflow, 1);
    rx_clear = 1'b1;
    @(negedge clk);
    rx_clear = 1'b0;
    chk(rx_count == 3'd0, "R9 clear empties", rx_count, 0);
    chk(rx_overflow == 1'b0, "R9 clear drops flag", rx_overflow, 0);

    summary();
    $finish;
  end

endmodule